// File: doc/BRIEF.md
# Multi-Channel DMA Shared Status Register Bank

This block is the shared register bank that sits in front of the channel engines of an 18-channel DMA controller. For every channel it keeps one bit each of channel enable, interrupt enable, completion flag A, completion flag B and error. Software never overwrites these vectors. It changes them through separate aliases: a set address and a clear address for the two enable vectors, and write-one-to-clear addresses for the three flag vectors. The channel engines raise flags through per-channel event inputs. The engines also supply active and busy vectors, which software reads here.

A one-bit master enable in the control register gates the channel enables that leave the block. Writes to three command addresses become one-cycle per-channel pulses toward the engines: mark the descriptor valid, fire a trigger, or abort. An abort reaches only channels that are both disabled and idle. The block reduces the flag vectors to two summary bits, "an enabled interrupt is pending" and "an error is pending", and drives a single interrupt line from their OR. The bus side is a single-cycle port. A write is taken on the clock edge while the write strobe is high. Read data is combinational from the address.

Top module: `dma_shr_top`

## Requirements
- R1: After reset the master enable, the channel enables, the interrupt enables, flags A, flags B, the error flags and all three pulse outputs are zero, and the interrupt line is low.
- R2: Ones written to address 2 set the matching channel enables, and ones written to address 3 clear them. Zero bits leave channels unchanged. Address 2 reads back the enable vector, and address 3 reads zero.
- R3: Ones written to address 7 set the matching interrupt enables, and ones written to address 8 clear them. Zero bits leave them unchanged. Address 7 reads back the interrupt-enable vector, and address 8 reads zero.
- R4: A high bit on the flag A, flag B or error event input sets that channel's bit, which reads at address 9, 10 or 6 respectively. Writing a 1 to a bit at those addresses clears it, and a 0 leaves it unchanged.
- R5: When an event input and a write-one-to-clear hit the same flag bit in the same cycle, the bit ends set.
- R6: Address 1 reads bit 1 = OR over channels of ((flag A or flag B) and interrupt enable), and bit 2 = OR of all error bits. Every other bit reads zero. The interrupt line equals bit 1 OR bit 2.
- R7: Bit 0 of address 0 is the master enable. The other bits of address 0 read zero. The channel-enable output equals the enable vector when the master enable is 1, and is zero otherwise.
- R8: A write to address 11 or 12 drives the written channel bits on the valid or trigger pulse output for exactly the one cycle after the write edge. Both addresses read zero.
- R9: A write to address 13 pulses the abort output for one cycle, only on written channels that are disabled and not busy at the write edge.
- R10: Addresses 4 and 5 read the active and busy input vectors. Bits 18 and above of every register read zero.
- R11: Addresses 14 to 31 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data |
| chActive | input | 18 | Per-channel active status from the engines |
| chBusy | input | 18 | Per-channel busy status from the engines |
| hwFlagA | input | 18 | Per-channel flag A set events |
| hwFlagB | input | 18 | Per-channel flag B set events |
| hwErr | input | 18 | Per-channel error set events |
| chEnable | output | 18 | Channel enables gated by the master enable |
| validPulse | output | 18 | One-cycle descriptor-valid pulses |
| trigPulse | output | 18 | One-cycle trigger pulses |
| abortPulse | output | 18 | One-cycle qualified abort pulses |
| irqOut | output | 1 | Combined interrupt line |

## Verification
The bench hits a flag bit with an event and a write-one-to-clear in the same cycle. A design that lets the clear win would lose that event and read the bit as zero. It sets a flag on a channel whose interrupt enable is off and checks that the summary stays low. A design that skips the enable mask would raise the interrupt line there. It sends an abort over a mix of enabled, busy and idle channels, so a missing busy or enable qualification shows up as extra pulse bits. It also writes all ones to the enable-set address and to unmapped addresses, which catches bits leaking above channel 17 and writes decoded into stray state.

// File: rtl/dma_shr_pkg.sv
package dma_shr_pkg;

  localparam int REG_ADDR_W = 5;

  // Word addresses of the shared registers
  localparam logic [REG_ADDR_W-1:0] ADR_CTRL   = 5'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_STAT   = 5'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_EN_SET = 5'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_EN_CLR = 5'd3;
  localparam logic [REG_ADDR_W-1:0] ADR_ACTIVE = 5'd4;
  localparam logic [REG_ADDR_W-1:0] ADR_BUSY   = 5'd5;
  localparam logic [REG_ADDR_W-1:0] ADR_ERR    = 5'd6;
  localparam logic [REG_ADDR_W-1:0] ADR_IE_SET = 5'd7;
  localparam logic [REG_ADDR_W-1:0] ADR_IE_CLR = 5'd8;
  localparam logic [REG_ADDR_W-1:0] ADR_FLAG_A = 5'd9;
  localparam logic [REG_ADDR_W-1:0] ADR_FLAG_B = 5'd10;
  localparam logic [REG_ADDR_W-1:0] ADR_VALID  = 5'd11;
  localparam logic [REG_ADDR_W-1:0] ADR_TRIG   = 5'd12;
  localparam logic [REG_ADDR_W-1:0] ADR_ABORT  = 5'd13;

  typedef enum logic [3:0] {
    RD_NONE, RD_CTRL, RD_STAT, RD_EN, RD_ACT,
    RD_BSY, RD_ERR, RD_IE, RD_FA, RD_FB
  } rdSel_e;

  // Strobes from the address decoder to the register datapath
  typedef struct packed {
    logic   wrCtrl;
    logic   setEn;
    logic   clrEn;
    logic   setIe;
    logic   clrIe;
    logic   clrErr;
    logic   clrA;
    logic   clrB;
    logic   fireValid;
    logic   fireTrig;
    logic   fireAbort;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/dma_shr_ctrl.sv
module dma_shr_ctrl
  import dma_shr_pkg::*;
(
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output regStrobe_t            strb
);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    case (regAddr)
      ADR_CTRL: begin
        strb.wrCtrl = regWe;
        strb.rdSel  = RD_CTRL;
      end
      ADR_STAT:   strb.rdSel = RD_STAT;
      ADR_EN_SET: begin
        strb.setEn = regWe;
        strb.rdSel = RD_EN;
      end
      ADR_EN_CLR: strb.clrEn = regWe;
      ADR_ACTIVE: strb.rdSel = RD_ACT;
      ADR_BUSY:   strb.rdSel = RD_BSY;
      ADR_ERR: begin
        strb.clrErr = regWe;
        strb.rdSel  = RD_ERR;
      end
      ADR_IE_SET: begin
        strb.setIe = regWe;
        strb.rdSel = RD_IE;
      end
      ADR_IE_CLR: strb.clrIe = regWe;
      ADR_FLAG_A: begin
        strb.clrA  = regWe;
        strb.rdSel = RD_FA;
      end
      ADR_FLAG_B: begin
        strb.clrB  = regWe;
        strb.rdSel = RD_FB;
      end
      ADR_VALID:  strb.fireValid = regWe;
      ADR_TRIG:   strb.fireTrig  = regWe;
      ADR_ABORT:  strb.fireAbort = regWe;
      default:    strb.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/dma_shr_dp.sv
module dma_shr_dp
  import dma_shr_pkg::*;
#(
  parameter int NUM_CH = 18,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] chActive,
  input  logic [NUM_CH-1:0] chBusy,
  input  logic [NUM_CH-1:0] hwFlagA,
  input  logic [NUM_CH-1:0] hwFlagB,
  input  logic [NUM_CH-1:0] hwErr,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] enVec,
  output logic [NUM_CH-1:0] flagA,
  output logic              masterEn,
  output logic [NUM_CH-1:0] validPulse,
  output logic [NUM_CH-1:0] trigPulse,
  output logic [NUM_CH-1:0] abortPulse,
  output logic              irqOut
);

  logic [NUM_CH-1:0] wrBits;
  logic              unusedHiBits;
  logic [NUM_CH-1:0] ieVec, flagB, errVec;
  logic [NUM_CH-1:0] enNext, ieNext, aNext, bNext, errNext, abortReq;
  logic              irqAny, errAny;

  assign wrBits       = wrData[NUM_CH-1:0];
  assign unusedHiBits = ^wrData[DATA_W-1:NUM_CH];

  // Per-channel next-state slices; event sets dominate software clears
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign enNext[c]   = (enVec[c] | (strb.setEn & wrBits[c])) & ~(strb.clrEn & wrBits[c]);
    assign ieNext[c]   = (ieVec[c] | (strb.setIe & wrBits[c])) & ~(strb.clrIe & wrBits[c]);
    assign aNext[c]    = hwFlagA[c] | (flagA[c]  & ~(strb.clrA   & wrBits[c]));
    assign bNext[c]    = hwFlagB[c] | (flagB[c]  & ~(strb.clrB   & wrBits[c]));
    assign errNext[c]  = hwErr[c]   | (errVec[c] & ~(strb.clrErr & wrBits[c]));
    assign abortReq[c] = strb.fireAbort & wrBits[c] & ~enVec[c] & ~chBusy[c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterEn   <= 1'b0;
      enVec      <= '0;
      ieVec      <= '0;
      flagA      <= '0;
      flagB      <= '0;
      errVec     <= '0;
      validPulse <= '0;
      trigPulse  <= '0;
      abortPulse <= '0;
    end else begin
      if (strb.wrCtrl) masterEn <= wrData[0];
      enVec      <= enNext;
      ieVec      <= ieNext;
      flagA      <= aNext;
      flagB      <= bNext;
      errVec     <= errNext;
      validPulse <= strb.fireValid ? wrBits : '0;
      trigPulse  <= strb.fireTrig  ? wrBits : '0;
      abortPulse <= abortReq;
    end
  end

  assign irqAny = |((flagA | flagB) & ieVec);
  assign errAny = |errVec;
  assign irqOut = irqAny | errAny;

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_CTRL: rdData[0] = masterEn;
      RD_STAT: begin
        rdData[1] = irqAny;
        rdData[2] = errAny;
      end
      RD_EN:   rdData[NUM_CH-1:0] = enVec;
      RD_ACT:  rdData[NUM_CH-1:0] = chActive;
      RD_BSY:  rdData[NUM_CH-1:0] = chBusy;
      RD_ERR:  rdData[NUM_CH-1:0] = errVec;
      RD_IE:   rdData[NUM_CH-1:0] = ieVec;
      RD_FA:   rdData[NUM_CH-1:0] = flagA;
      RD_FB:   rdData[NUM_CH-1:0] = flagB;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_shr_top.sv
module dma_shr_top
  import dma_shr_pkg::*;
#(
  parameter int NUM_CH = 18,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic [NUM_CH-1:0]     chActive,
  input  logic [NUM_CH-1:0]     chBusy,
  input  logic [NUM_CH-1:0]     hwFlagA,
  input  logic [NUM_CH-1:0]     hwFlagB,
  input  logic [NUM_CH-1:0]     hwErr,
  output logic [NUM_CH-1:0]     chEnable,
  output logic [NUM_CH-1:0]     validPulse,
  output logic [NUM_CH-1:0]     trigPulse,
  output logic [NUM_CH-1:0]     abortPulse,
  output logic                  irqOut
);

  regStrobe_t        strb;
  logic [NUM_CH-1:0] enVec;
  logic [NUM_CH-1:0] flagA;
  logic              masterEn;

  dma_shr_ctrl uCtrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strb    (strb)
  );

  dma_shr_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (regWdata),
    .chActive   (chActive),
    .chBusy     (chBusy),
    .hwFlagA    (hwFlagA),
    .hwFlagB    (hwFlagB),
    .hwErr      (hwErr),
    .rdData     (regRdata),
    .enVec      (enVec),
    .flagA      (flagA),
    .masterEn   (masterEn),
    .validPulse (validPulse),
    .trigPulse  (trigPulse),
    .abortPulse (abortPulse),
    .irqOut     (irqOut)
  );

  assign chEnable = enVec & {NUM_CH{masterEn}};

endmodule

// File: rtl/dma_shr_chk.sv
module dma_shr_chk
  import dma_shr_pkg::*;
#(
  parameter int NUM_CH = 18,
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWe,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0]     regWdata,
  input logic [DATA_W-1:0]     regRdata,
  input logic [NUM_CH-1:0]     chBusy,
  input logic [NUM_CH-1:0]     hwFlagA,
  input logic [NUM_CH-1:0]     enVec,
  input logic [NUM_CH-1:0]     flagA,
  input logic [NUM_CH-1:0]     validPulse,
  input logic [NUM_CH-1:0]     trigPulse,
  input logic [NUM_CH-1:0]     abortPulse
);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (hwFlagA != '0) |=> ((flagA & $past(hwFlagA)) == $past(hwFlagA)));  // R5

  AST_ABORT_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADR_ABORT) |=>
      ((abortPulse & ($past(chBusy) | $past(enVec))) == '0));  // R9

  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> (validPulse == '0 && trigPulse == '0 && abortPulse == '0));  // R8

  AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADR_EN_CLR) |=>
      ((enVec & $past(regWdata[NUM_CH-1:0])) == '0));  // R2

  AST_IE_SET_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADR_EN_SET) |=>
      ((enVec & $past(regWdata[NUM_CH-1:0])) == $past(regWdata[NUM_CH-1:0])));  // R2

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:NUM_CH] == '0);  // R10

endmodule

bind dma_shr_top dma_shr_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uChk (.*);

// File: tb/tb_dma_shr_top.sv
module tb_dma_shr_top;

  localparam int NUM_CH = 18;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWe = 1'b0;
  logic [4:0]        regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic [NUM_CH-1:0] chActive = '0, chBusy = '0, hwFlagA = '0, hwFlagB = '0, hwErr = '0;
  logic [NUM_CH-1:0] chEnable, validPulse, trigPulse, abortPulse;
  logic              irqOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  dma_shr_top #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dut (.*);

  typedef struct packed {
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t TBL [NVEC] = '{
    '{5'd2,  32'hFFFF_FFFF, 5'd2,  32'h0003_FFFF, 8'd10},  // R10 upper bits dropped
    '{5'd3,  32'h0000_0005, 5'd2,  32'h0003_FFFA, 8'd2},   // R2 clear alias
    '{5'd2,  32'h0000_0000, 5'd2,  32'h0003_FFFA, 8'd2},   // R2 zero bits no effect
    '{5'd3,  32'h0003_FFFA, 5'd2,  32'h0000_0000, 8'd2},   // R2
    '{5'd7,  32'h0003_0001, 5'd7,  32'h0003_0001, 8'd3},   // R3 set alias
    '{5'd8,  32'h0001_0000, 5'd7,  32'h0002_0001, 8'd3},   // R3 clear alias
    '{5'd8,  32'h0000_0000, 5'd8,  32'h0000_0000, 8'd3},   // R3 clear alias reads 0
    '{5'd0,  32'hFFFF_FFFF, 5'd0,  32'h0000_0001, 8'd7},   // R7 only bit 0
    '{5'd0,  32'h0000_0000, 5'd0,  32'h0000_0000, 8'd7},   // R7
    '{5'd31, 32'hFFFF_FFFF, 5'd31, 32'h0000_0000, 8'd11},  // R11
    '{5'd14, 32'hFFFF_FFFF, 5'd2,  32'h0000_0000, 8'd11},  // R11 no state change
    '{5'd11, 32'h0000_000F, 5'd11, 32'h0000_0000, 8'd8}    // R8 reads zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic doRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic readChk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    doRead(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readChk("R1 ctrl", 5'd0, 0);
    readChk("R1 stat", 5'd1, 0);
    readChk("R1 enable", 5'd2, 0);
    readChk("R1 ie", 5'd7, 0);
    readChk("R1 flagA", 5'd9, 0);
    readChk("R1 flagB", 5'd10, 0);
    readChk("R1 err", 5'd6, 0);
    chk("R1 pulses", {14'd0, validPulse | trigPulse | abortPulse}, 0);
    chk("R1 irq", {31'd0, irqOut}, 0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      doWrite(TBL[i].wa, TBL[i].wd);
      doRead(TBL[i].ra, v);
      chk($sformatf("R%0d row %0d", TBL[i].req, i), v, TBL[i].exp);
    end
    // ie now 0x20001, enables 0, master off

    // R4 flag A event, R6 summary
    @(negedge clk); hwFlagA = 18'h1;
    @(negedge clk); hwFlagA = '0;
    readChk("R4 flagA set", 5'd9, 32'h1);
    readChk("R6 stat irq", 5'd1, 32'h2);
    chk("R6 irq line", {31'd0, irqOut}, 1);
    doWrite(5'd9, 32'h0003_FFFE);
    readChk("R4 zero bits keep", 5'd9, 32'h1);
    doWrite(5'd9, 32'h1);
    readChk("R4 w1c", 5'd9, 32'h0);
    readChk("R6 stat clear", 5'd1, 32'h0);
    chk("R6 irq low", {31'd0, irqOut}, 0);

    // R5 set wins over same-cycle clear
    @(negedge clk);
    regWe = 1'b1; regAddr = 5'd9; regWdata = 32'h8; hwFlagA = 18'h8;
    @(negedge clk);
    regWe = 1'b0; hwFlagA = '0;
    readChk("R5 set wins", 5'd9, 32'h8);
    readChk("R6 masked flag", 5'd1, 32'h0);
    doWrite(5'd9, 32'h8);

    // Flag B on top channel
    @(negedge clk); hwFlagB = 18'h20000;
    @(negedge clk); hwFlagB = '0;
    readChk("R4 flagB set", 5'd10, 32'h20000);
    readChk("R6 stat flagB", 5'd1, 32'h2);
    doWrite(5'd10, 32'h20000);
    readChk("R4 flagB w1c", 5'd10, 32'h0);

    // Error flag
    @(negedge clk); hwErr = 18'h20;
    @(negedge clk); hwErr = '0;
    readChk("R4 err set", 5'd6, 32'h20);
    readChk("R6 stat err", 5'd1, 32'h4);
    chk("R6 irq on err", {31'd0, irqOut}, 1);
    doWrite(5'd6, 32'h20);
    readChk("R4 err w1c", 5'd6, 32'h0);
    chk("R6 irq off", {31'd0, irqOut}, 0);

    // R10 status inputs
    @(negedge clk); chActive = 18'h2AAAA; chBusy = 18'h15555;
    readChk("R10 active", 5'd4, 32'h2AAAA);
    readChk("R10 busy", 5'd5, 32'h15555);
    chBusy = '0; chActive = '0;

    // R7 master gating
    doWrite(5'd2, 32'h3);
    #1 chk("R7 gated off", {14'd0, chEnable}, 0);
    doWrite(5'd0, 32'h1);
    #1 chk("R7 gated on", {14'd0, chEnable}, 32'h3);

    // R8 trigger pulse lasts one cycle
    doWrite(5'd12, 32'h104);
    chk("R8 trig pulse", {14'd0, trigPulse}, 32'h104);
    chk("R8 no valid", {14'd0, validPulse}, 0);
    @(negedge clk);
    chk("R8 trig ends", {14'd0, trigPulse}, 0);

    // R9 abort qualified: ch0/1 enabled, ch2 busy, ch3 idle
    @(negedge clk); chBusy = 18'h4;
    doWrite(5'd13, 32'hF);
    chk("R9 abort idle only", {14'd0, abortPulse}, 32'h8);
    @(negedge clk);
    chk("R9 abort ends", {14'd0, abortPulse}, 0);
    chBusy = '0;
    readChk("R9 abort reads zero", 5'd13, 0);

    // R8 valid pulse on all channels
    doWrite(5'd11, 32'hFFFF_FFFF);
    chk("R8 valid pulse", {14'd0, validPulse}, 32'h3FFFF);
    chk("R9 no abort", {14'd0, abortPulse}, 0);
    @(negedge clk);
    chk("R8 valid ends", {14'd0, validPulse}, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule